// File: doc/BRIEF.md
# Master-Slave Sample Serializer

This block turns four parallel sample lanes, delivered at a quarter of the fast clock rate, into one sample per fast-clock cycle for a converter core. A two-bit select counter steps through the lanes in the order A, B, C, D. The whole four-lane word is captured on the edge where the counter wraps. A second register after the lane multiplexer drives the core. The block also produces a low-rate clock at one quarter of the fast rate, so the upstream data source can launch its words with it.

A role pin picks master or slave operation. A master counts freely and drives its low-rate clock out. A slave takes the low-rate clock from a master and passes it through a synchronizer. It then reloads its own counter so that its lane sequence matches the master's on the same fast-clock edge. The slave regenerates the low-rate clock in the aligned phase and drives it on to its own data source. Two serializers wired this way emit matching lanes together, for example as the I and Q halves of a modulator. Alignment is only valid if the received clock lags the master's by no more than one fast-clock period.

Top module: `msync_serializer`

## Requirements
- R1: While `arst_n` is low, `sel_o` is 0, `dout_o` is 0x800 and `lclk_o` is 1. `locked_o` is 1 for a master and 0 for a slave.
- R2: In master mode `sel_o` advances by one every fast cycle (0, 1, 2, 3, 0, ...), whatever `lclk_i` does.
- R3: `lclk_o` is high while `sel_o` is 0 or 1 and low while it is 2 or 3, giving the fast clock divided by 4 at 50 % duty.
- R4: All four lanes are captured together on the edge where `sel_o` goes from 3 to 0. Values on `lanes_i` at any other edge do not reach `dout_o`.
- R5: Lane A is `lanes_i[11:0]`, B is `[23:12]`, C is `[35:24]` and D is `[47:36]`. When `sel_o` reads k, `dout_o` holds lane (k-1) mod 4 of the captured word, so A appears while `sel_o` is 1 and D while it is 0.
- R6: After reset, `dout_o` stays at mid-scale 0x800 until the first captured word has started to come out.
- R7: In slave mode, a rising edge of `lclk_i` passes through a two-stage synchronizer. The counter is then loaded with 3 on the third fast edge after the edge is first sampled. A slave fed from a master's `lclk_o` therefore shows the same `sel_o` and `dout_o` as the master. A slave fed one fast cycle late shows the same values one cycle later.
- R8: A slave raises `locked_o` when two consecutive received edges each find its counter already at the value the reload would give. A received edge that finds any other count clears `locked_o`.
- R9: `role_i` = 1 (pin left open, pulled up) selects master. `role_i` = 0 (pin grounded) selects slave.
- R10: A slave drives `lclk_o` from its own aligned counter, so once locked to a master its `lclk_o` equals the master's.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sample clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| role_i | input | 1 | 1 = master, 0 = slave |
| lanes_i | input | 48 | Four 12-bit lanes, A in the low bits |
| lclk_i | input | 1 | Low-rate clock received from a master (slave mode) |
| lclk_o | output | 1 | Low-rate clock, fast clock divided by 4 |
| dout_o | output | 12 | Serialized sample to the converter core |
| sel_o | output | 2 | Current lane-select count |
| locked_o | output | 1 | Slave alignment achieved (always 1 for a master) |

## Verification
The words used have lanes that are all distinct, all zero, all ones, alternating bit patterns and values next to mid-scale. Together they show whether lane order or bit packing is wrong, and whether a stuck bit or mid-scale is mistaken for real data. Between captures the bench drives the complement of the next word, so any capture outside the wrap edge shows up at once. A slave fed straight from a master is compared edge for edge with the master. The same slave fed one fast cycle late must lose lock, lock again, and then trail the master by exactly one cycle. This separates a correct reload value from an off-by-one.

// File: rtl/msync_pkg.sv
package msync_pkg;

  // Default geometry of the serializer.
  localparam int unsigned SAMPLE_W_DEF  = 12;
  localparam int unsigned LANE_CNT_DEF  = 4;
  localparam int unsigned SYNC_DEPTH_DEF = 2;

  // Role encoding on the mode pin: an open pin is pulled up to master.
  typedef enum logic {
    ROLE_SLAVE  = 1'b0,
    ROLE_MASTER = 1'b1
  } role_e;

endpackage

// File: rtl/msync_rst_sync.sv
module msync_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  // Assert immediately, release only after STAGES clean edges.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/msync_sel_gen.sv
module msync_sel_gen
  import msync_pkg::*;
#(
  parameter int unsigned LANE_CNT   = LANE_CNT_DEF,
  parameter int unsigned SYNC_DEPTH = SYNC_DEPTH_DEF,
  localparam int unsigned SEL_W     = $clog2(LANE_CNT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             is_master,
  input  logic             lclk_i,
  output logic [SEL_W-1:0] sel_o,
  output logic             wrap_o,
  output logic             lclk_o,
  output logic             locked_o
);

  // The counter value the master holds when a slave sees its edge:
  // SYNC_DEPTH cycles of synchronizer plus one cycle for the reload.
  localparam logic [SEL_W-1:0] LOAD_SEL   = SEL_W'((SYNC_DEPTH + 1) % LANE_CNT);
  localparam logic [SEL_W-1:0] EXPECT_SEL = SEL_W'(SYNC_DEPTH % LANE_CNT);
  localparam logic [SEL_W-1:0] HALF_SEL   = SEL_W'(LANE_CNT / 2);

  logic [SEL_W-1:0]    sel_q, sel_d;
  logic [SYNC_DEPTH:0] sync_q, sync_d;
  logic                lclk_q, lclk_d;
  logic                lock_q, lock_d;
  logic                hit_q, hit_d;
  logic                rise;
  logic                on_time;

  // Synchronizer for the received low-rate clock, plus one history bit.
  always_comb begin
    sync_d  = {sync_q[SYNC_DEPTH-1:0], lclk_i};
    rise    = sync_q[SYNC_DEPTH-1] & ~sync_q[SYNC_DEPTH];
    on_time = (sel_q == EXPECT_SEL);
  end

  // Next-state: free count, or reload on a received edge in slave mode.
  always_comb begin
    if (!is_master && rise) sel_d = LOAD_SEL;
    else                    sel_d = sel_q + SEL_W'(1);
    lclk_d = (sel_d < HALF_SEL);
    hit_d  = hit_q;
    lock_d = lock_q;
    if (!is_master && rise) begin
      hit_d  = on_time;
      lock_d = on_time & hit_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      sync_q <= '1;
      lclk_q <= 1'b1;
      hit_q  <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      sel_q  <= sel_d;
      sync_q <= sync_d;
      lclk_q <= lclk_d;
      hit_q  <= hit_d;
      lock_q <= lock_d;
    end
  end

  assign sel_o    = sel_q;
  assign wrap_o   = (sel_d == '0);
  assign lclk_o   = lclk_q;
  assign locked_o = is_master | lock_q;

  // R2: a master steps once per cycle.
  assert_master_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    is_master |=> sel_q == SEL_W'($past(sel_q) + SEL_W'(1)));

  // R3: output clock high for the first half of the count.
  assert_lclk_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lclk_q == (sel_q < HALF_SEL));

  // R7: a received edge reloads the counter.
  assert_slave_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_master && rise) |=> sel_q == LOAD_SEL);

  // R8: an edge at the wrong count drops lock.
  assert_lock_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_master && rise && sel_q != EXPECT_SEL) |=> !locked_o);

endmodule

// File: rtl/msync_lane_path.sv
module msync_lane_path
  import msync_pkg::*;
#(
  parameter int unsigned SAMPLE_W = SAMPLE_W_DEF,
  parameter int unsigned LANE_CNT = LANE_CNT_DEF,
  localparam int unsigned SEL_W   = $clog2(LANE_CNT),
  localparam int unsigned WORD_W  = SAMPLE_W * LANE_CNT
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [WORD_W-1:0]   lanes_i,
  input  logic                wrap_i,
  input  logic [SEL_W-1:0]    sel_i,
  output logic [SAMPLE_W-1:0] dout_o
);

  localparam logic [SAMPLE_W-1:0] MID_CODE = {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic [WORD_W-1:0]   cap_q, cap_d;
  logic                valid_q, valid_d;
  logic [SAMPLE_W-1:0] dout_q, dout_d;
  logic [SAMPLE_W-1:0] lane_view [LANE_CNT];

  for (genvar g = 0; g < LANE_CNT; g++) begin : g_unpack
    assign lane_view[g] = cap_q[g*SAMPLE_W +: SAMPLE_W];
  end

  always_comb begin
    cap_d   = wrap_i ? lanes_i : cap_q;
    valid_d = valid_q | wrap_i;
    dout_d  = valid_q ? lane_view[sel_i] : MID_CODE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q   <= '0;
      valid_q <= 1'b0;
      dout_q  <= MID_CODE;
    end else begin
      cap_q   <= cap_d;
      valid_q <= valid_d;
      dout_q  <= dout_d;
    end
  end

  assign dout_o = dout_q;

  // R6: nothing but mid-scale before the first word is in.
  assert_mid_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |=> dout_q == MID_CODE);

  // R5: lane A follows a zero select by one register.
  assert_lane_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && sel_i == '0) |=> dout_q == $past(cap_q[SAMPLE_W-1:0]));

  // R4: captured word only moves on a wrap.
  assert_cap_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_i |=> $stable(cap_q));

endmodule

// File: rtl/msync_serializer.sv
module msync_serializer
  import msync_pkg::*;
#(
  parameter int unsigned SAMPLE_W   = SAMPLE_W_DEF,
  parameter int unsigned LANE_CNT   = LANE_CNT_DEF,
  parameter int unsigned SYNC_DEPTH = SYNC_DEPTH_DEF,
  localparam int unsigned SEL_W     = $clog2(LANE_CNT),
  localparam int unsigned WORD_W    = SAMPLE_W * LANE_CNT
) (
  input  logic                clk,
  input  logic                arst_n,
  input  logic                role_i,
  input  logic [WORD_W-1:0]   lanes_i,
  input  logic                lclk_i,
  output logic                lclk_o,
  output logic [SAMPLE_W-1:0] dout_o,
  output logic [SEL_W-1:0]    sel_o,
  output logic                locked_o
);

  logic             rst_core_n;
  logic             is_master;
  logic             wrap;
  logic [SEL_W-1:0] sel;

  assign is_master = (role_e'(role_i) == ROLE_MASTER);

  msync_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_core_n)
  );

  msync_sel_gen #(
    .LANE_CNT   (LANE_CNT),
    .SYNC_DEPTH (SYNC_DEPTH)
  ) u_sel (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .is_master (is_master),
    .lclk_i    (lclk_i),
    .sel_o     (sel),
    .wrap_o    (wrap),
    .lclk_o    (lclk_o),
    .locked_o  (locked_o)
  );

  msync_lane_path #(
    .SAMPLE_W (SAMPLE_W),
    .LANE_CNT (LANE_CNT)
  ) u_path (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .lanes_i (lanes_i),
    .wrap_i  (wrap),
    .sel_i   (sel),
    .dout_o  (dout_o)
  );

  assign sel_o = sel;

endmodule

// File: tb/sim_msync_serializer.sv
`timescale 1ns/1ps
module sim_msync_serializer;

  localparam int NV = 8;
  localparam logic [47:0] TBL [NV] = '{
    48'hDDD_CCC_BBB_AAA, 48'h000_000_000_000, 48'hFFF_FFF_FFF_FFF,
    48'h800_7FF_001_FFE, 48'h555_AAA_555_AAA, 48'h123_456_789_ABC,
    48'hF00_0F0_00F_800, 48'h001_002_004_008
  };

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic [47:0] lanes = '0;
  logic junk = 1'b0;
  logic use_dly = 1'b0;
  logic lclk_dly = 1'b1;
  logic s_lclk_in;

  logic [11:0] m_dout, s_dout;
  logic [1:0]  m_sel, s_sel;
  logic        m_lclk, s_lclk, m_lock, s_lock;

  int total = 0, bad = 0;
  bit mon = 0, have_cap = 0, live = 0, garb_en = 1, slv_cmp = 1, saw_unlock = 0;
  int settle = 0, prev_s = 0, tix = 0, consumed = 0;
  logic [47:0] cur_w = '0, prev_w = '0;
  logic [11:0] lm;

  always #2 clk = ~clk;  // 250 MHz
  initial begin #1; forever begin #4; junk = ~junk; end end
  always @(posedge clk) lclk_dly <= m_lclk;
  assign s_lclk_in = use_dly ? lclk_dly : m_lclk;

  msync_serializer u0 (
    .clk(clk), .arst_n(arst_n), .role_i(1'b1), .lanes_i(lanes), .lclk_i(junk),
    .lclk_o(m_lclk), .dout_o(m_dout), .sel_o(m_sel), .locked_o(m_lock));

  msync_serializer u1 (
    .clk(clk), .arst_n(arst_n), .role_i(1'b0), .lanes_i(lanes), .lclk_i(s_lclk_in),
    .lclk_o(s_lclk), .dout_o(s_dout), .sel_o(s_sel), .locked_o(s_lock));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    int s;
    logic [47:0] w;
    logic [11:0] e;
    s = int'(m_sel);
    if (settle == 0) chk(s == (prev_s + 1) % 4, "R2 master count", s, (prev_s + 1) % 4);
    else settle--;
    chk(m_lclk == (s < 2), "R3 lclk shape", m_lclk, s < 2);
    if (live) begin
      w = (s == 0) ? prev_w : cur_w;
      e = w[((s + 3) % 4) * 12 +: 12];
      chk(m_dout == e, "R5 lane order / R4 capture", m_dout, e);
    end else begin
      chk(m_dout == 12'h800, "R6 midscale", m_dout, 12'h800);
    end
    if (s == 0 && have_cap) live = 1;
    prev_s = s;
    if (slv_cmp && s_lock) begin
      chk(s_sel == m_sel, "R7 slave sel", s_sel, m_sel);
      chk(s_dout == m_dout, "R7 slave dout", s_dout, m_dout);
      chk(s_lclk == m_lclk, "R10 slave lclk", s_lclk, m_lclk);
    end
    if (!s_lock) saw_unlock = 1;
  endtask

  task automatic step();
    @(negedge clk);
    if (mon) check_all();
    if (mon && m_sel == 2'd3) begin
      lanes = TBL[tix];
      prev_w = cur_w;
      cur_w = TBL[tix];
      tix = (tix + 1) % NV;
      have_cap = 1;
      consumed++;
    end else if (garb_en) begin
      lanes = ~TBL[tix];  // R4: must never be captured
    end
  endtask

  task automatic check_reset();
    chk(m_sel == 2'd0, "R1 sel", m_sel, 0);
    chk(m_dout == 12'h800, "R1 dout", m_dout, 12'h800);
    chk(m_lclk == 1'b1, "R1 lclk", m_lclk, 1);
    chk(m_lock == 1'b1, "R9 master locked", m_lock, 1);
    chk(s_lock == 1'b0, "R9 slave unlocked", s_lock, 0);
    chk(s_dout == 12'h800, "R1 slave dout", s_dout, 12'h800);
  endtask

  task automatic release_reset();
    arst_n = 1'b1;
    mon = 1; have_cap = 0; live = 0; settle = 3; prev_s = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_reset();
    release_reset();

    // Table walk: each word must come out lane by lane.
    for (int v = 0; v < NV; v++) begin
      int tgt;
      tgt = consumed + 1;
      while (consumed < tgt) step();
    end
    repeat (6) step();
    chk(s_lock == 1'b1, "R8 slave lock", s_lock, 1);

    // Slave fed one fast cycle late.
    garb_en = 0; slv_cmp = 0; saw_unlock = 0; use_dly = 1;
    repeat (12) step();
    chk(saw_unlock, "R8 lock lost on late edge", saw_unlock, 1);
    repeat (12) step();
    chk(s_lock == 1'b1, "R8 relock late", s_lock, 1);
    for (int k = 0; k < 8; k++) begin
      lm = m_dout;
      step();
      chk(s_sel == 2'((m_sel + 2'd3)), "R7 late sel", s_sel, 2'((m_sel + 2'd3)));
      chk(s_dout == lm, "R7 late dout", s_dout, lm);
    end

    // Back to direct feed.
    use_dly = 0;
    repeat (24) step();
    chk(s_lock == 1'b1, "R8 relock direct", s_lock, 1);
    slv_cmp = 1; garb_en = 1;
    repeat (16) step();

    // Mid-run reset.
    @(negedge clk);
    arst_n = 1'b0; mon = 0;
    @(negedge clk);
    check_reset();
    release_reset();
    repeat (40) step();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule